// File: doc/BRIEF.md
# Processor exception entry controller

This block is the part of a small RISC control coprocessor that decides when the processor leaves normal execution for its exception handler, and how it gets back. Each cycle it can see an exception request with a cause code, along with the address of the current instruction, a flag that marks that instruction as sitting in a branch delay slot, and a flag for the 16-bit compressed instruction mode. It also samples eight interrupt lines. It keeps a status register with these fields: an interrupt enable, an exception level, an error level, a two-bit privilege field and an eight-bit interrupt mask. It also keeps a cause register and a restart address register.

When an exception or an accepted interrupt is taken, the block saves the restart address. The address is pulled back to the branch when the fault is in a delay slot, and it is tagged in bit 0 with the compressed mode. The block then sets the exception level, records the cause, and for one cycle raises a redirect strobe to a fixed vector together with a strobe that forces 32-bit instruction mode. A return pulse unwinds the error or exception level and presents the resume address and the resume instruction mode. A status write port lets the surrounding pipeline load the status register.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, statusOut is 0, epcOut is 0, privMode is 00 (kernel), and redirect, force32, intReq and resumeValid are 0.
- R2: A taken exception, with the exception level clear and the instruction not in a delay slot, loads the restart register (epcOut) with instrAddr, with bit 0 replaced by the mode tag. The new value is visible the cycle after the request.
- R3: If the instruction is in a delay slot and isaCompact is 0, the restart register holds instrAddr minus 4 and causeBd is 1. In compressed mode the delay-slot flag is ignored: there is no rewind and causeBd is 0.
- R4: Bit 0 of the restart register is 1 only when compactEnable and isaCompact are both 1 at the time the exception is taken. Otherwise bit 0 is 0.
- R5: Taking an exception sets the exception level (statusOut bit 1) and loads causeCode. In the following cycle it raises redirect and force32 for one cycle, while vectorAddr shows the fixed vector 0x80000180.
- R6: While the exception level is already set, a new exception updates causeCode and raises redirect again, but leaves epcOut unchanged.
- R7: intReq is 1 only when IE = 1, the exception level is 0, the error level is 0, and at least one latched pending bit has its mask bit set.
- R8: privMode is 00 (kernel) whenever the exception level or the error level is set. Otherwise it follows the privilege field: 00 kernel, 01 supervisor, 10 user, and 11 is reported as 10 (user).
- R9: An eretPulse clears the error level if it is set, and otherwise clears the exception level. The next cycle it raises resumeValid for one cycle, with resumeAddr equal to epcOut with bit 0 cleared and resumeCompact equal to epcOut bit 0.
- R10: intLines are latched every cycle into causePending. An accepted interrupt is taken as an exception with cause code 0. An excReq in the same cycle wins, and its own code is recorded.
- R11: statusWe loads the status register from statusWdata using this layout: bit 0 IE, bit 1 exception level, bit 2 error level, bits 4:3 privilege field, bits 15:8 interrupt mask, other bits 0. statusOut reads back the same layout. Exception entry has priority over a return, and a return has priority over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception request this cycle |
| excCode | input | 5 | Cause code of the request |
| instrAddr | input | 32 | Address of the current instruction |
| inDelaySlot | input | 1 | Current instruction is in a branch delay slot |
| isaCompact | input | 1 | Processor is in 16-bit compressed mode |
| compactEnable | input | 1 | Compressed instructions are enabled |
| intLines | input | 8 | Interrupt lines (2 software, 6 hardware) |
| eretPulse | input | 1 | Return from exception |
| statusWe | input | 1 | Status register write enable |
| statusWdata | input | 16 | Status write data |
| privMode | output | 2 | Effective privilege mode |
| intReq | output | 1 | Gated interrupt request |
| redirect | output | 1 | One-cycle strobe to jump to the vector |
| vectorAddr | output | 32 | Exception vector address |
| force32 | output | 1 | Force 32-bit instruction mode |
| resumeValid | output | 1 | One-cycle return strobe |
| resumeAddr | output | 32 | Resume address |
| resumeCompact | output | 1 | Resume in compressed mode |
| epcOut | output | 32 | Restart address register |
| causeCode | output | 5 | Recorded cause code |
| causeBd | output | 1 | Recorded delay-slot flag |
| causePending | output | 8 | Latched interrupt lines |
| statusOut | output | 16 | Status register |

## Verification
Some rules are checked by the bound assertions on every cycle:
- kernel mode whenever either level bit is set;
- the interrupt gate conditions;
- the strobe and exception-level set that follow every request;
- the hold of the restart register while the exception level is already set;
- the mode tag in bit 0;
- the resume address produced by a return.

Other behaviour only shows up in the bench's scenarios:
- the exact rewind arithmetic in the delay slot, and its suppression in compressed mode;
- the user reading of the privilege value 11;
- the unwinding order from error level to exception level;
- the priority of a request over a pending interrupt, with the right cause code.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    PM_KERNEL = 2'b00,
    PM_SUPER  = 2'b01,
    PM_USER   = 2'b10
  } priv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeExc;
    logic saveEpc;
    logic doEret;
    logic doWrite;
  } ctrl_t;

  localparam int STATUS_W = 16;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int NINT  = 8,
  parameter int CODEW = 5
) (
  input  logic             excReq,
  input  logic [CODEW-1:0] excCode,
  input  logic             eretPulse,
  input  logic             statusWe,
  input  logic             ie,
  input  logic             exl,
  input  logic             erl,
  input  logic [1:0]       ksu,
  input  logic [NINT-1:0]  im,
  input  logic [NINT-1:0]  pending,
  output ctrl_t            ctrl,
  output logic [CODEW-1:0] codeSel,
  output logic             intReq,
  output logic [1:0]       privMode
);
  logic [NINT-1:0] maskedLines;
  logic            gateOpen;
  logic            takeAny;

  // per-line masking
  for (genvar i = 0; i < NINT; i++) begin : g_mask
    assign maskedLines[i] = pending[i] & im[i];
  end

  assign gateOpen = ie & ~exl & ~erl;
  assign intReq   = gateOpen & (|maskedLines);
  assign takeAny  = excReq | intReq;

  // interrupts are taken with cause code 0
  assign codeSel = excReq ? excCode : '0;

  always_comb begin
    ctrl.takeExc = takeAny;
    ctrl.saveEpc = takeAny & ~exl;
    ctrl.doEret  = eretPulse & ~takeAny;
    ctrl.doWrite = statusWe & ~takeAny & ~eretPulse;
  end

  always_comb begin
    if (exl || erl) begin
      privMode = PM_KERNEL;
    end else begin
      unique case (ksu)
        2'b00:   privMode = PM_KERNEL;
        2'b01:   privMode = PM_SUPER;
        default: privMode = PM_USER;
      endcase
    end
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int          AW    = 32,
  parameter int          NINT  = 8,
  parameter int          CODEW = 5,
  parameter logic [31:0] VEC   = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CODEW-1:0] codeSel,
  input  logic [AW-1:0]    instrAddr,
  input  logic             inDelaySlot,
  input  logic             isaCompact,
  input  logic             compactEnable,
  input  logic [NINT-1:0]  intLines,
  input  logic [STATUS_W-1:0] statusWdata,
  output logic             ie,
  output logic             exl,
  output logic             erl,
  output logic [1:0]       ksu,
  output logic [NINT-1:0]  im,
  output logic [NINT-1:0]  pending,
  output logic [AW-1:0]    epc,
  output logic [CODEW-1:0] causeCode,
  output logic             causeBd,
  output logic             redirect,
  output logic             force32,
  output logic [AW-1:0]    vectorAddr,
  output logic             resumeValid,
  output logic [AW-1:0]    resumeAddr,
  output logic             resumeCompact,
  output logic [STATUS_W-1:0] statusOut
);
  localparam int IMLO = 8;
  localparam int PADW = IMLO - 5;

  logic          rewind;
  logic [AW-1:0] baseAddr;
  logic [AW-1:0] epcNext;

  assign rewind   = inDelaySlot & ~isaCompact;
  assign baseAddr = rewind ? (instrAddr - AW'(4)) : instrAddr;
  assign epcNext  = {baseAddr[AW-1:1], compactEnable & isaCompact};

  // status register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      exl <= 1'b0;
      erl <= 1'b0;
      ksu <= 2'b00;
      im  <= '0;
    end else if (ctrl.takeExc) begin
      exl <= 1'b1;
    end else if (ctrl.doEret) begin
      if (erl) erl <= 1'b0;
      else     exl <= 1'b0;
    end else if (ctrl.doWrite) begin
      ie  <= statusWdata[0];
      exl <= statusWdata[1];
      erl <= statusWdata[2];
      ksu <= statusWdata[4:3];
      im  <= statusWdata[IMLO +: NINT];
    end
  end

  // cause and restart registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc       <= '0;
      causeCode <= '0;
      causeBd   <= 1'b0;
      pending   <= '0;
    end else begin
      pending <= intLines;
      if (ctrl.takeExc) causeCode <= codeSel;
      if (ctrl.saveEpc) begin
        epc     <= epcNext;
        causeBd <= rewind;
      end
    end
  end

  // strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect      <= 1'b0;
      force32       <= 1'b0;
      resumeValid   <= 1'b0;
      resumeAddr    <= '0;
      resumeCompact <= 1'b0;
    end else begin
      redirect    <= ctrl.takeExc;
      force32     <= ctrl.takeExc;
      resumeValid <= ctrl.doEret;
      if (ctrl.doEret) begin
        resumeAddr    <= {epc[AW-1:1], 1'b0};
        resumeCompact <= epc[0];
      end
    end
  end

  assign vectorAddr = VEC[AW-1:0];
  assign statusOut  = {im, {PADW{1'b0}}, ksu, erl, exl, ie};
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int          AW    = 32,
  parameter int          NINT  = 8,
  parameter int          CODEW = 5,
  parameter logic [31:0] VEC   = 32'h8000_0180
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                excReq,
  input  logic [CODEW-1:0]    excCode,
  input  logic [AW-1:0]       instrAddr,
  input  logic                inDelaySlot,
  input  logic                isaCompact,
  input  logic                compactEnable,
  input  logic [NINT-1:0]     intLines,
  input  logic                eretPulse,
  input  logic                statusWe,
  input  logic [STATUS_W-1:0] statusWdata,
  output logic [1:0]          privMode,
  output logic                intReq,
  output logic                redirect,
  output logic [AW-1:0]       vectorAddr,
  output logic                force32,
  output logic                resumeValid,
  output logic [AW-1:0]       resumeAddr,
  output logic                resumeCompact,
  output logic [AW-1:0]       epcOut,
  output logic [CODEW-1:0]    causeCode,
  output logic                causeBd,
  output logic [NINT-1:0]     causePending,
  output logic [STATUS_W-1:0] statusOut
);
  ctrl_t            ctrl;
  logic [CODEW-1:0] codeSel;
  logic             ie, exl, erl;
  logic [1:0]       ksu;
  logic [NINT-1:0]  im;

  exc_ctrl #(.NINT(NINT), .CODEW(CODEW)) u_ctrl (
    .excReq(excReq), .excCode(excCode), .eretPulse(eretPulse),
    .statusWe(statusWe), .ie(ie), .exl(exl), .erl(erl), .ksu(ksu),
    .im(im), .pending(causePending), .ctrl(ctrl), .codeSel(codeSel),
    .intReq(intReq), .privMode(privMode)
  );

  exc_datapath #(.AW(AW), .NINT(NINT), .CODEW(CODEW), .VEC(VEC)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .codeSel(codeSel),
    .instrAddr(instrAddr), .inDelaySlot(inDelaySlot),
    .isaCompact(isaCompact), .compactEnable(compactEnable),
    .intLines(intLines), .statusWdata(statusWdata),
    .ie(ie), .exl(exl), .erl(erl), .ksu(ksu), .im(im),
    .pending(causePending), .epc(epcOut), .causeCode(causeCode),
    .causeBd(causeBd), .redirect(redirect), .force32(force32),
    .vectorAddr(vectorAddr), .resumeValid(resumeValid),
    .resumeAddr(resumeAddr), .resumeCompact(resumeCompact),
    .statusOut(statusOut)
  );
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int AW   = 32,
  parameter int NINT = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            excReq,
  input logic            isaCompact,
  input logic            compactEnable,
  input logic            eretPulse,
  input logic            intReq,
  input logic [1:0]      privMode,
  input logic            redirect,
  input logic            force32,
  input logic            resumeValid,
  input logic [AW-1:0]   resumeAddr,
  input logic [AW-1:0]   epcOut,
  input logic [NINT-1:0] causePending,
  input logic [15:0]     statusOut
);
  logic lvlExc, lvlErr, ieBit;
  logic [NINT-1:0] imBits;
  assign ieBit  = statusOut[0];
  assign lvlExc = statusOut[1];
  assign lvlErr = statusOut[2];
  assign imBits = statusOut[8 +: NINT];

  assert_kernel_on_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvlExc || lvlErr) |-> privMode == 2'b00);

  assert_int_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    intReq |-> (ieBit && !lvlExc && !lvlErr && ((causePending & imBits) != '0)));

  assert_entry_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    excReq |=> (redirect && force32 && lvlExc));

  assert_epc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (excReq && lvlExc) |=> $stable(epcOut));

  assert_epc_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (excReq && !lvlExc) |=> epcOut[0] == $past(compactEnable && isaCompact));

  assert_resume_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eretPulse && !excReq && !intReq) |=>
      (resumeValid && resumeAddr == ($past(epcOut) & ~AW'(1))));
endmodule

bind exc_entry_ctrl exc_entry_checker #(.AW(AW), .NINT(NINT)) u_chk (
  .clk(clk), .rst_n(rst_n), .excReq(excReq), .isaCompact(isaCompact),
  .compactEnable(compactEnable), .eretPulse(eretPulse), .intReq(intReq),
  .privMode(privMode), .redirect(redirect), .force32(force32),
  .resumeValid(resumeValid), .resumeAddr(resumeAddr), .epcOut(epcOut),
  .causePending(causePending), .statusOut(statusOut)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        excReq = 0;
  logic [4:0]  excCode = 0;
  logic [31:0] instrAddr = 0;
  logic        inDelaySlot = 0, isaCompact = 0, compactEnable = 0;
  logic [7:0]  intLines = 0;
  logic        eretPulse = 0, statusWe = 0;
  logic [15:0] statusWdata = 0;
  logic [1:0]  privMode;
  logic        intReq, redirect, force32, resumeValid, resumeCompact, causeBd;
  logic [31:0] vectorAddr, resumeAddr, epcOut;
  logic [4:0]  causeCode;
  logic [7:0]  causePending;
  logic [15:0] statusOut;

  always #10 clk = ~clk;

  exc_entry_ctrl u_dut (.*);

  typedef enum int {F_PRIV, F_STAT, F_EPC, F_REDIR, F_VEC, F_F32, F_CODE,
                    F_BD, F_PEND, F_INT, F_RV, F_RADDR, F_RCOMP} field_t;
  typedef struct {
    field_t      fld;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  sampleEv;
  int    nChecks = 0, nFails = 0;
  bit    done = 0;

  function automatic logic [31:0] getField(field_t f);
    case (f)
      F_PRIV:  return 32'(privMode);
      F_STAT:  return 32'(statusOut);
      F_EPC:   return epcOut;
      F_REDIR: return 32'(redirect);
      F_VEC:   return vectorAddr;
      F_F32:   return 32'(force32);
      F_CODE:  return 32'(causeCode);
      F_BD:    return 32'(causeBd);
      F_PEND:  return 32'(causePending);
      F_INT:   return 32'(intReq);
      F_RV:    return 32'(resumeValid);
      F_RADDR: return resumeAddr;
      default: return 32'(resumeCompact);
    endcase
  endfunction

  // monitor: pops expectations and compares against the outputs
  initial forever begin
    @(sampleEv);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = getField(it.fld);
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s field %s actual=%h expected=%h", it.req, it.fld.name(), act, it.exp);
      end
    end
  end

  task automatic push(field_t f, logic [31:0] e, string r);
    item_t it;
    it.fld = f; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic flush();
    ->sampleEv;
    wait (q.size() == 0);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    excReq = 0; eretPulse = 0; statusWe = 0; inDelaySlot = 0;
  endtask

  task automatic wrStatus(logic [15:0] d);
    statusWe = 1; statusWdata = d; step(); idle();
  endtask

  task automatic raise(logic [4:0] c, logic [31:0] a, logic ds, logic cm, logic en);
    excReq = 1; excCode = c; instrAddr = a; inDelaySlot = ds;
    isaCompact = cm; compactEnable = en; step(); idle(); isaCompact = 0;
  endtask

  task automatic eret();
    eretPulse = 1; step(); idle();
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R1 reset state
    push(F_PRIV, 0, "R1"); push(F_STAT, 0, "R1"); push(F_EPC, 0, "R1");
    push(F_REDIR, 0, "R1"); push(F_F32, 0, "R1"); push(F_INT, 0, "R1");
    push(F_RV, 0, "R1"); flush();

    // R11 write user mode, IE=1
    wrStatus(16'h0011);
    push(F_STAT, 32'h0011, "R11"); push(F_PRIV, 2, "R8"); flush();

    // R2/R5 plain exception
    raise(5'd3, 32'h1000, 0, 0, 1);
    push(F_REDIR, 1, "R5"); push(F_VEC, 32'h8000_0180, "R5"); push(F_F32, 1, "R5");
    push(F_EPC, 32'h1000, "R2"); push(F_CODE, 3, "R5"); push(F_BD, 0, "R2");
    push(F_STAT, 32'h0013, "R5"); push(F_PRIV, 0, "R8"); flush();
    step();
    push(F_REDIR, 0, "R5"); push(F_F32, 0, "R5"); flush();

    // R9 return clears exception level
    eret();
    push(F_RV, 1, "R9"); push(F_RADDR, 32'h1000, "R9"); push(F_RCOMP, 0, "R9");
    push(F_STAT, 32'h0011, "R9"); push(F_PRIV, 2, "R9"); flush();
    step();
    push(F_RV, 0, "R9"); flush();

    // R3 delay slot rewind in 32-bit mode
    raise(5'd4, 32'h2004, 1, 0, 1);
    push(F_EPC, 32'h2000, "R3"); push(F_BD, 1, "R3"); flush();
    eret();

    // R3/R4 delay flag ignored in compressed mode, tag bit set
    raise(5'd5, 32'h3002, 1, 1, 1);
    push(F_EPC, 32'h3003, "R4"); push(F_BD, 0, "R3"); flush();
    eret();
    push(F_RADDR, 32'h3002, "R9"); push(F_RCOMP, 1, "R9"); flush();

    // R4 tag clear when compressed disabled; R6 hold while level set
    raise(5'd6, 32'h4000, 0, 1, 0);
    push(F_EPC, 32'h4000, "R4"); flush();
    raise(5'd7, 32'h5000, 0, 0, 1);
    push(F_EPC, 32'h4000, "R6"); push(F_CODE, 7, "R6"); push(F_REDIR, 1, "R6"); flush();
    eret();
    push(F_STAT, 32'h0011, "R9"); flush();

    // R9 error level unwinds first, R8 supervisor
    wrStatus(16'h000E);
    push(F_PRIV, 0, "R8"); flush();
    eret();
    push(F_STAT, 32'h000A, "R9"); push(F_PRIV, 0, "R8"); flush();
    eret();
    push(F_STAT, 32'h0008, "R9"); push(F_PRIV, 1, "R8"); flush();

    // R8 privilege value 11 reads as user
    wrStatus(16'h0018);
    push(F_PRIV, 2, "R8"); flush();

    // R7 gating by mask
    wrStatus(16'h0401);
    intLines = 8'h02; step();
    push(F_PEND, 32'h02, "R10"); push(F_INT, 0, "R7"); flush();
    instrAddr = 32'h6000;
    intLines = 8'h04; step();
    push(F_PEND, 32'h04, "R10"); push(F_INT, 1, "R7"); flush();
    intLines = 8'h00; step();
    push(F_REDIR, 1, "R10"); push(F_CODE, 0, "R10"); push(F_EPC, 32'h6000, "R10");
    push(F_INT, 0, "R7"); flush();
    eret();

    // R7 IE clear blocks
    wrStatus(16'h0400);
    intLines = 8'h04; step();
    push(F_INT, 0, "R7"); flush();
    step();
    push(F_REDIR, 0, "R7"); flush();
    intLines = 8'h00;
    wrStatus(16'h0401);

    // R10 request beats a pending interrupt
    intLines = 8'h04; step();
    push(F_INT, 1, "R10"); flush();
    raise(5'd9, 32'h7000, 0, 0, 1);
    intLines = 8'h00;
    push(F_CODE, 9, "R10"); push(F_REDIR, 1, "R10"); push(F_EPC, 32'h7000, "R10"); flush();
    eret();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule